// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block executes a small 32-bit integer instruction subset on a classic five-stage in-order pipeline: fetch, decode with register read, execute, memory access and write-back. Each instruction moves forward one stage per clock through four stage registers. A new instruction enters every cycle. A single instruction takes five cycles from fetch to register write. The supported operations are word load, word store, register-register add, subtract, bitwise and, bitwise or, signed set-less-than, and branch when two registers are equal.

Instruction memory, data memory and a 32-entry register file are internal. The environment fills both memories before reset is released. The block has no hazard detection, no forwarding and no squashing. Software or the test program must keep dependent instructions three fetch slots apart. It must also accept that the three instructions fetched after a branch always complete. The only outputs are the current fetch address and the register-file write port as seen at write-back.

Top module: `pipe5_core`

## Requirements
- R1: While rst_ni is low, pc_o is 0 and rf_we_o is 0. The first fetch after release is from address 0.
- R2: Unless a taken branch redirects, pc_o increases by 4 on every clock. An instruction that is not a branch never redirects, even when its ALU result is zero.
- R3: R-type instructions use opcode bits[31:26]=0, rs=[25:21], rt=[20:16], rd=[15:11] and funct=[5:0]. The funct codes are 0x20 add, 0x22 subtract, 0x24 and, 0x25 or. The result of rs op rt is written to rd. The write appears on the write taps in cycle k+4 for an instruction fetched in cycle k, and one write-tap result appears per cycle.
- R4: A load (opcode 0x23) writes data memory word (rs + sign-extended bits[15:0]) to register rt. Negative offsets are allowed.
- R5: A store (opcode 0x2B) writes register rt to data memory word (rs + sign-extended bits[15:0]). A load issued one slot later returns the stored value.
- R6: A branch (opcode 0x04) whose rs equals rt makes pc_o equal (fetch address + 4 + (sign-extended bits[15:0] << 2)) in cycle t+4 for a branch fetched in cycle t. The three instructions fetched after it still execute.
- R7: A branch whose rs and rt differ leaves the PC stepping by 4.
- R8: Register 0 reads as zero. A write to it is dropped, and rf_we_o never shows address 0. This holds even when the dropped write and a read of register 0 fall in the same cycle.
- R9: A register written in the write-back stage is seen by an instruction reading it in decode in that same cycle.
- R10: Set-less-than (funct 0x2A) writes 1 to rd when rs is less than rt as signed 32-bit values, and 0 otherwise.
- R11: An opcode outside the supported set, or an R-type funct outside the supported set, writes no register, writes no memory and does not redirect the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pc_o | output | 32 | Current fetch address |
| rf_we_o | output | 1 | Register-file write taking effect this cycle (nonzero destination) |
| rf_waddr_o | output | 5 | Destination register of that write |
| rf_wdata_o | output | 32 | Value being written |

## Verification
A decode or stage-register fault shows up on the write taps exactly four cycles after the faulty instruction was fetched, as a wrong value, a wrong register, a missing write or a write in the wrong cycle. A fault in the redirect path shows up on pc_o one cycle after the branch leaves the memory stage, or as a PC that jumps when it should step. Loaded values and stored data reach the taps one cycle later, through a later load. The program is laid out so that every write has a known cycle, register and value. A shift by even one cycle is therefore reported.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;
  localparam int NREG   = 1 << REG_AW;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic reg_wr;
    logic mem_to_reg;
  } wb_ctrl_t;

  typedef struct packed {
    logic mem_rd;
    logic mem_wr;
    logic branch;
  } mem_ctrl_t;

  typedef struct packed {
    logic    alu_src;  // 1: immediate as operand b
    logic    dst_rd;   // 1: destination is rd, else rt
    alu_op_e alu_op;
  } ex_ctrl_t;

  typedef struct packed {
    wb_ctrl_t  wb;
    mem_ctrl_t mem;
    ex_ctrl_t  ex;
  } ctrl_t;

  typedef struct packed {
    logic [XLEN-1:0] instr;
    logic [XLEN-1:0] npc;
  } ifid_t;

  typedef struct packed {
    ctrl_t             ctrl;
    logic [XLEN-1:0]   npc;
    logic [XLEN-1:0]   a;
    logic [XLEN-1:0]   b;
    logic [XLEN-1:0]   imm;
    logic [REG_AW-1:0] rd;
    logic [REG_AW-1:0] rt;
  } idex_t;

  typedef struct packed {
    wb_ctrl_t          wb;
    mem_ctrl_t         mem;
    logic [XLEN-1:0]   target;
    logic [XLEN-1:0]   alu_res;
    logic [XLEN-1:0]   b;
    logic [REG_AW-1:0] dst;
  } exmem_t;

  typedef struct packed {
    wb_ctrl_t          wb;
    logic [XLEN-1:0]   mem_data;
    logic [XLEN-1:0]   alu_res;
    logic [REG_AW-1:0] dst;
  } memwb_t;
endpackage

// File: rtl/pipe5_ram.sv
module pipe5_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [DW-1:0] addr_i,   // byte address, word aligned
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] idx;
  logic          unused_addr;

  assign idx         = addr_i[AW+1:2];
  assign unused_addr = ^{addr_i[DW-1:AW+2], addr_i[1:0]};
  assign rdata_o     = mem_q[idx];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx] <= wdata_i;
  end
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile
  import pipe5_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] waddr_i,
  input  logic [XLEN-1:0]   wdata_i,
  input  logic [REG_AW-1:0] raddr_a_i,
  output logic [XLEN-1:0]   rdata_a_o,
  input  logic [REG_AW-1:0] raddr_b_i,
  output logic [XLEN-1:0]   rdata_b_o
);
  logic [XLEN-1:0] regs_q [NREG];
  logic            wr_en;

  assign wr_en = we_i && (waddr_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (wr_en) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  // reads see a write landing in the same cycle
  function automatic logic [XLEN-1:0] rd_port(input logic [REG_AW-1:0] ra);
    if (ra == '0)                    return '0;
    else if (wr_en && waddr_i == ra) return wdata_i;
    else                             return regs_q[ra];
  endfunction

  assign rdata_a_o = rd_port(raddr_a_i);
  assign rdata_b_o = rd_port(raddr_b_i);
endmodule

// File: rtl/pipe5_decode.sv
module pipe5_decode
  import pipe5_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o           = '0;
    ctrl_o.ex.alu_op = ALU_ADD;
    unique case (opcode_i)
      OP_RTYPE: begin
        ctrl_o.ex.dst_rd = 1'b1;
        ctrl_o.wb.reg_wr = 1'b1;
        unique case (funct_i)
          FN_ADD:  ctrl_o.ex.alu_op = ALU_ADD;
          FN_SUB:  ctrl_o.ex.alu_op = ALU_SUB;
          FN_AND:  ctrl_o.ex.alu_op = ALU_AND;
          FN_OR:   ctrl_o.ex.alu_op = ALU_OR;
          FN_SLT:  ctrl_o.ex.alu_op = ALU_SLT;
          default: ctrl_o.wb.reg_wr = 1'b0;
        endcase
      end
      OP_LOAD: begin
        ctrl_o.ex.alu_src     = 1'b1;
        ctrl_o.mem.mem_rd     = 1'b1;
        ctrl_o.wb.reg_wr      = 1'b1;
        ctrl_o.wb.mem_to_reg  = 1'b1;
      end
      OP_STORE: begin
        ctrl_o.ex.alu_src = 1'b1;
        ctrl_o.mem.mem_wr = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.ex.alu_op  = ALU_SUB;
        ctrl_o.mem.branch = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
  import pipe5_pkg::*;
(
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  alu_op_e         op_i,
  output logic [XLEN-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      ALU_SUB: res_o = a_i - b_i;
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      ALU_SLT: res_o = {{(XLEN-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      default: res_o = a_i + b_i;
    endcase
  end
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [XLEN-1:0]   pc_o,
  output logic              rf_we_o,
  output logic [REG_AW-1:0] rf_waddr_o,
  output logic [XLEN-1:0]   rf_wdata_o
);
  localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

  logic [XLEN-1:0] pc_q, pc_d, pc_plus4;
  ifid_t  ifid_q, ifid_d;
  idex_t  idex_q, idex_d;
  exmem_t exmem_q, exmem_d;
  memwb_t memwb_q, memwb_d;

  logic            redirect;
  logic [XLEN-1:0] instr;
  logic [XLEN-1:0] rs_val, rt_val;
  ctrl_t           dec_ctrl;
  logic [XLEN-1:0] alu_b, alu_res;
  logic [XLEN-1:0] dmem_rdata;
  logic            wb_we;
  logic [XLEN-1:0] wb_data;
  logic [XLEN-1:0] unused_imem_rdata;

  // IF
  assign pc_plus4 = pc_q + PC_STEP;
  assign redirect = exmem_q.mem.branch && (exmem_q.alu_res == '0);
  assign pc_d     = redirect ? exmem_q.target : pc_plus4;

  pipe5_ram #(.DEPTH(IMEM_DEPTH), .DW(XLEN)) u_imem (
    .clk_i   (clk_i),
    .we_i    (1'b0),
    .addr_i  (pc_q),
    .wdata_i ('0),
    .rdata_o (instr)
  );
  assign unused_imem_rdata = '0;

  assign ifid_d.instr = instr;
  assign ifid_d.npc   = pc_plus4;

  // ID
  pipe5_decode u_dec (
    .opcode_i (ifid_q.instr[31:26]),
    .funct_i  (ifid_q.instr[5:0]),
    .ctrl_o   (dec_ctrl)
  );

  pipe5_regfile u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wb_we),
    .waddr_i   (memwb_q.dst),
    .wdata_i   (wb_data),
    .raddr_a_i (ifid_q.instr[25:21]),
    .rdata_a_o (rs_val),
    .raddr_b_i (ifid_q.instr[20:16]),
    .rdata_b_o (rt_val)
  );

  always_comb begin
    idex_d.ctrl = dec_ctrl;
    idex_d.npc  = ifid_q.npc;
    idex_d.a    = rs_val;
    idex_d.b    = rt_val;
    idex_d.imm  = {{(XLEN-16){ifid_q.instr[15]}}, ifid_q.instr[15:0]};
    idex_d.rd   = ifid_q.instr[15:11];
    idex_d.rt   = ifid_q.instr[20:16];
  end

  // EX
  assign alu_b = idex_q.ctrl.ex.alu_src ? idex_q.imm : idex_q.b;

  pipe5_alu u_alu (
    .a_i   (idex_q.a),
    .b_i   (alu_b),
    .op_i  (idex_q.ctrl.ex.alu_op),
    .res_o (alu_res)
  );

  always_comb begin
    exmem_d.wb      = idex_q.ctrl.wb;
    exmem_d.mem     = idex_q.ctrl.mem;
    exmem_d.target  = idex_q.npc + {idex_q.imm[XLEN-3:0], 2'b00};
    exmem_d.alu_res = alu_res;
    exmem_d.b       = idex_q.b;
    exmem_d.dst     = idex_q.ctrl.ex.dst_rd ? idex_q.rd : idex_q.rt;
  end

  // MEM
  pipe5_ram #(.DEPTH(DMEM_DEPTH), .DW(XLEN)) u_dmem (
    .clk_i   (clk_i),
    .we_i    (exmem_q.mem.mem_wr),
    .addr_i  (exmem_q.alu_res),
    .wdata_i (exmem_q.b),
    .rdata_o (dmem_rdata)
  );

  always_comb begin
    memwb_d.wb       = exmem_q.wb;
    memwb_d.mem_data = exmem_q.mem.mem_rd ? dmem_rdata : '0;
    memwb_d.alu_res  = exmem_q.alu_res;
    memwb_d.dst      = exmem_q.dst;
  end

  // WB
  assign wb_we   = memwb_q.wb.reg_wr;
  assign wb_data = memwb_q.wb.mem_to_reg ? memwb_q.mem_data : memwb_q.alu_res;

  // stage registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      ifid_q  <= '0;
      idex_q  <= '0;
      exmem_q <= '0;
      memwb_q <= '0;
    end else begin
      pc_q    <= pc_d;
      ifid_q  <= ifid_d;
      idex_q  <= idex_d;
      exmem_q <= exmem_d;
      memwb_q <= memwb_d;
    end
  end

  assign pc_o       = pc_q;
  assign rf_we_o    = wb_we && (memwb_q.dst != '0);
  assign rf_waddr_o = memwb_q.dst;
  assign rf_wdata_o = wb_data;
endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk
  import pipe5_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [XLEN-1:0]   pc_o,
  input logic              rf_we_o,
  input logic [REG_AW-1:0] rf_waddr_o,
  input logic [XLEN-1:0]   rf_wdata_o,
  input logic              redirect_i,
  input logic [XLEN-1:0]   target_i
);
  a_r1_reset_state: assert property (@(posedge clk_i)
    !rst_ni |-> (pc_o == '0 && !rf_we_o));

  a_r2_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !redirect_i |=> pc_o == $past(pc_o) + XLEN'(4));

  a_r6_redirect_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |=> pc_o == $past(target_i));

  a_r8_no_zero_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> rf_waddr_o != '0);

  a_r3_wdata_known: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> !$isunknown(rf_wdata_o));
endmodule

bind pipe5_core pipe5_core_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pc_o       (pc_o),
  .rf_we_o    (rf_we_o),
  .rf_waddr_o (rf_waddr_o),
  .rf_wdata_o (rf_wdata_o),
  .redirect_i (redirect),
  .target_i   (exmem_q.target)
);

// File: tb/pipe5_core_test.sv
module pipe5_core_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic [31:0] pc_o;
  logic        rf_we_o;
  logic [4:0]  rf_waddr_o;
  logic [31:0] rf_wdata_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit run = 1'b0;
  bit done = 1'b0;

  typedef struct {
    int          cyc;
    logic [4:0]  r;
    logic [31:0] v;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #2 clk_i = ~clk_i;

  pipe5_core uut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pc_o       (pc_o),
    .rf_we_o    (rf_we_o),
    .rf_waddr_o (rf_waddr_o),
    .rf_wdata_o (rf_wdata_o)
  );

  function automatic logic [31:0] r_ins(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] i_ins(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // driver side of the scoreboard
  task automatic expect_wr(int fetch_slot, int r, logic [31:0] v, string tag);
    exp_t e;
    e.cyc = fetch_slot + 4;
    e.r   = 5'(r);
    e.v   = v;
    e.tag = tag;
    q.push_back(e);
  endtask

  function automatic int pc_exp(int n);
    if (n <= 25)      return 4 * n;
    else if (n <= 32) return 112 + 4 * (n - 26);
    else              return 124;
  endfunction

  always @(posedge clk_i) if (run) cyc <= cyc + 1;

  // monitor
  always @(negedge clk_i) begin
    if (run && !done) begin
      if (cyc >= 1 && cyc <= 33) begin
        string t;
        t = (cyc == 26 || cyc == 33) ? "R6" : (cyc == 25 ? "R7" : "R2");
        check(t, pc_o, 32'(pc_exp(cyc)), "pc");
      end
      if (rf_we_o) begin
        if (q.size() == 0) begin
          check("R8/R11", {27'd0, rf_waddr_o}, 32'hFFFF_FFFF, "unexpected write");
        end else begin
          exp_t e;
          e = q.pop_front();
          check(e.tag, 32'(cyc), 32'(e.cyc), "write cycle");
          check(e.tag, {27'd0, rf_waddr_o}, {27'd0, e.r}, "write reg");
          check(e.tag, rf_wdata_o, e.v, "write data");
        end
      end
    end
  end

  initial begin
    #(4 * 5000);
    if (!done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1 rst_ni = 1'b0;
    for (int i = 0; i < 64; i++) begin
      uut.u_imem.mem_q[i] = 32'h0;
      uut.u_dmem.mem_q[i] = 32'h0;
    end
    uut.u_dmem.mem_q[0] = 32'd5;
    uut.u_dmem.mem_q[1] = 32'd7;
    uut.u_dmem.mem_q[2] = 32'hFFFF_FFFD;
    uut.u_dmem.mem_q[3] = 32'h0F0F_00FF;
    uut.u_dmem.mem_q[4] = 32'h00FF_0FF0;

    uut.u_imem.mem_q[0]  = i_ins(6'h23, 0, 1, 0);
    uut.u_imem.mem_q[1]  = i_ins(6'h23, 0, 2, 4);
    uut.u_imem.mem_q[2]  = i_ins(6'h23, 0, 3, 8);
    uut.u_imem.mem_q[3]  = i_ins(6'h23, 0, 4, 12);
    uut.u_imem.mem_q[4]  = i_ins(6'h23, 0, 5, 16);
    uut.u_imem.mem_q[5]  = r_ins(1, 2, 6, 6'h20);
    uut.u_imem.mem_q[6]  = r_ins(1, 2, 7, 6'h22);
    uut.u_imem.mem_q[7]  = r_ins(4, 5, 8, 6'h24);
    uut.u_imem.mem_q[8]  = r_ins(4, 5, 9, 6'h25);
    uut.u_imem.mem_q[9]  = r_ins(3, 1, 10, 6'h2A);
    uut.u_imem.mem_q[10] = r_ins(1, 3, 11, 6'h2A);
    uut.u_imem.mem_q[11] = r_ins(1, 2, 0, 6'h20);
    uut.u_imem.mem_q[14] = r_ins(0, 2, 12, 6'h20);
    uut.u_imem.mem_q[17] = r_ins(12, 1, 13, 6'h20);
    uut.u_imem.mem_q[18] = i_ins(6'h2B, 0, 6, 40);
    uut.u_imem.mem_q[19] = i_ins(6'h23, 0, 14, 40);
    uut.u_imem.mem_q[20] = i_ins(6'h23, 13, 15, -4);
    uut.u_imem.mem_q[21] = i_ins(6'h04, 1, 12, 10);
    uut.u_imem.mem_q[22] = i_ins(6'h04, 6, 13, 5);
    uut.u_imem.mem_q[23] = r_ins(1, 1, 16, 6'h20);
    uut.u_imem.mem_q[25] = r_ins(2, 2, 17, 6'h20);
    uut.u_imem.mem_q[26] = r_ins(1, 2, 18, 6'h20);
    uut.u_imem.mem_q[27] = r_ins(1, 2, 18, 6'h20);
    uut.u_imem.mem_q[28] = r_ins(2, 1, 19, 6'h20);
    uut.u_imem.mem_q[29] = {6'h3F, 5'd1, 5'd20, 5'd20, 5'd0, 6'h20};
    uut.u_imem.mem_q[30] = r_ins(1, 2, 21, 6'h21);
    uut.u_imem.mem_q[31] = i_ins(6'h04, 0, 0, -1);

    expect_wr(0, 1, 32'd5, "R4");
    expect_wr(1, 2, 32'd7, "R4");
    expect_wr(2, 3, 32'hFFFF_FFFD, "R4");
    expect_wr(3, 4, 32'h0F0F_00FF, "R4");
    expect_wr(4, 5, 32'h00FF_0FF0, "R4");
    expect_wr(5, 6, 32'd12, "R3");
    expect_wr(6, 7, 32'hFFFF_FFFE, "R3");
    expect_wr(7, 8, 32'h000F_00F0, "R3");
    expect_wr(8, 9, 32'h0FFF_0FFF, "R3");
    expect_wr(9, 10, 32'd1, "R10");
    expect_wr(10, 11, 32'd0, "R10");
    expect_wr(14, 12, 32'd7, "R8");
    expect_wr(17, 13, 32'd12, "R9");
    expect_wr(19, 14, 32'd12, "R5");
    expect_wr(20, 15, 32'hFFFF_FFFD, "R4");
    expect_wr(23, 16, 32'd10, "R6");
    expect_wr(25, 17, 32'd14, "R6");
    expect_wr(26, 19, 32'd12, "R6");

    repeat (3) @(negedge clk_i);
    check("R1", pc_o, 32'h0, "pc in reset");
    check("R1", {31'd0, rf_we_o}, 32'h0, "write enable in reset");
    rst_ni = 1'b1;
    run = 1'b1;
    check("R1", pc_o, 32'h0, "first fetch address");

    while (cyc < 45) @(negedge clk_i);
    @(negedge clk_i);
    check("R3", 32'(q.size()), 32'd0, "writes still outstanding");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule